// File: doc/BRIEF.md
# External Parallel Bus Strobe Controller

This block turns single requests from an internal master into one asynchronous access on a 16-bit external parallel bus. A request carries an address, write data, a two-bit byte mask (bit 0 is the low byte `[7:0]`, bit 1 the high byte `[15:8]`), a write flag and a bank number. Five chip-select banks are served. Every bus output is active-low and driven from a flop.

Each bank has two configuration bits, a lane-enable bit and a 68-style bit. Together they choose how the chip select, output enable, write-enable and the two byte-lane pins behave during an access to that bank. A shared two-bit field sets how many clocks after the strobe goes active the external active-low wait input is first sampled. While wait is held low the strobe is stretched. Read data comes back with a one-cycle done pulse. The byte order is fixed little-endian, and a status output reports this as a constant 1.

Top module: `xbus_strobe_ctrl`

## Requirements
- R1: After reset, and with no access in progress, every chip select, `bus_oe_n`, `bus_we_n` and both lane pins are high. `busy`, `rsp_done`, `rsp_cfg_err` and `bus_doe` are low.
- R2: A request is accepted on a clock edge where `req_valid` is high, the block is idle and `req_bank` is below 5. `busy` is high from the next cycle until the done cycle, and is low in the done cycle. Requests made while busy, and requests naming bank 5, 6 or 7, have no effect.
- R3: Counting from the accept edge, the access takes these cycles:
  - cycle 1 is setup;
  - cycles 2 to 1+L are the strobe phase;
  - cycle 2+L is hold;
  - cycle 3+L is the done cycle, in which `rsp_done` is high for exactly that one cycle.
  In 80-type modes the bank's chip select is low in cycles 1 to 2+L. At most one chip select is low at any time.
- R4: With wait held high, L = `cfg_wait_sel` + 1. The encodings 0, 1, 2 and 3 give 1, 2, 3 and 4 strobe cycles, because wait is first sampled on the n-th rising edge after the strobe goes active.
- R5: If wait is low at the sampling edge, it is sampled again on every edge. The strobe ends at the first edge where wait is high, so each low sample adds one strobe cycle.
- R6: With lane-enable 0 and 68-style 0, the strobes work as follows:
  - On a write, each lane pin whose mask bit is 1 is low during the strobe phase, and `bus_we_n` stays high.
  - On a read, `bus_oe_n` is low during the strobe phase and both lane pins stay high.
- R7: With lane-enable 1 and 68-style 0, the lane pins equal the inverted mask for the whole setup-to-hold window. `bus_we_n` is the write strobe during the strobe phase and `bus_oe_n` is the read strobe.
- R8: With lane-enable 0 and 68-style 1, the strobes work as follows:
  - The chip select is low only during the strobe phase.
  - `bus_we_n` is low from setup to hold for a write and high for a read.
  - `bus_oe_n` stays high.
  - Masked lane pins are low during the strobe phase.
- R9: When both bits are 1 the access behaves exactly as in R6, and `rsp_cfg_err` is high in the done cycle.
- R10: Each bank uses its own bit pair. The pair and the wait field are captured at acceptance, and changing them during an access has no effect on that access.
- R11: For a read, `rsp_rdata` takes `bus_din` on the edge that ends the strobe phase and holds it. Bit `[7:0]` is lane 0, and `endian_le` is always 1.
- R12: From setup to hold, `bus_addr` holds the request address. For a write, `bus_doe` is high in that window and `bus_dout` holds the write data. Otherwise `bus_doe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 3 | Target bank 0..4 |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte mask, bit 0 = low byte |
| cfg_lane_en | input | 5 | Per-bank lane-enable bit |
| cfg_m68 | input | 5 | Per-bank 68-style bit |
| cfg_wait_sel | input | 2 | Wait sample point, n = value + 1 |
| busy | output | 1 | Access in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_cfg_err | output | 1 | Reserved mode pair used, valid with done |
| rsp_rdata | output | 16 | Captured read data |
| endian_le | output | 1 | Little-endian status, always 1 |
| bus_addr | output | 16 | External address |
| bus_dout | output | 16 | External write data |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 16 | External read data |
| bus_cs_n | output | 5 | Active-low chip selects |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_we_n | output | 1 | Active-low write enable / direction |
| bus_lane_n | output | 2 | Active-low byte-lane pins |
| bus_wait_n | input | 1 | Active-low external wait |

## Verification
The bench builds the block with its default parameters: five banks and a 16-bit bus. Every accepted access can therefore be compared pin by pin, cycle by cycle. At that size every bank, all four bit pairs, both directions, all four byte masks, all four wait encodings and wait stretches of zero and two clocks can be swept in full. The bit pairs of the other banks are set opposite to the target bank's pair. The target bank's pair and the wait field are flipped right after acceptance. Invalid bank numbers and a request made while busy are also driven.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } xb_state_e;

  // Effective signalling style of an access.
  typedef enum logic [1:0] {
    MODE_BSTRB = 2'd0,  // lane pins are per-byte write strobes
    MODE_BENA  = 2'd1,  // lane pins are byte enables, shared write strobe
    MODE_M68   = 2'd2   // chip select is the strobe, we_n is direction
  } xb_mode_e;

  // Map a bank's bit pair to its style. The reserved pair falls back to byte strobes.
  function automatic xb_mode_e pick_mode(input logic lane_en, input logic m68);
    case ({lane_en, m68})
      2'b10:   return MODE_BENA;
      2'b01:   return MODE_M68;
      default: return MODE_BSTRB;
    endcase
  endfunction

endpackage

// File: rtl/xbus_mode_sel.sv
module xbus_mode_sel
  import xbus_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int BANK_W    = 3
) (
  input  logic [NUM_BANKS-1:0] cfg_lane_en,
  input  logic [NUM_BANKS-1:0] cfg_m68,
  input  logic [BANK_W-1:0]    bank,
  output xb_mode_e             mode,
  output logic                 reserved,
  output logic                 bank_ok
);

  xb_mode_e bank_mode [NUM_BANKS];
  logic     bank_rsv  [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_mode[b] = pick_mode(cfg_lane_en[b], cfg_m68[b]);
    assign bank_rsv[b]  = cfg_lane_en[b] & cfg_m68[b];
  end

  assign bank_ok = (32'(bank) < NUM_BANKS);

  always_comb begin
    mode     = MODE_BSTRB;
    reserved = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank == BANK_W'(b)) begin
        mode     = bank_mode[b];
        reserved = bank_rsv[b];
      end
    end
  end

endmodule

// File: rtl/xbus_wait_timer.sv
module xbus_wait_timer #(
  parameter  int SEL_W = 2,
  localparam int CNT_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             ripe
);

  // The counter holds the number of rising edges seen since the strobe went active.
  logic [CNT_W-1:0] cnt_q;

  assign ripe = (cnt_q > {1'b0, sel});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(1);
    end else if (run && !ripe) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/xbus_pin_drive.sv
module xbus_pin_drive
  import xbus_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int BANK_W    = 3,
  parameter int LANES     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  xb_state_e            state_d,
  input  xb_mode_e             mode_d,
  input  logic                 wr_d,
  input  logic [BANK_W-1:0]    bank_d,
  input  logic [LANES-1:0]     mask_d,
  output logic [NUM_BANKS-1:0] cs_n,
  output logic                 oe_n,
  output logic                 we_n,
  output logic [LANES-1:0]     lane_n,
  output logic                 doe
);

  logic             access, strobe;
  logic             cs_on, oe_on, we_on;
  logic [LANES-1:0] lane_on;

  assign access = (state_d != ST_IDLE);
  assign strobe = (state_d == ST_STROBE);

  always_comb begin
    case (mode_d)
      MODE_BENA: begin
        cs_on   = access;
        oe_on   = strobe && !wr_d;
        we_on   = strobe && wr_d;
        lane_on = access ? mask_d : '0;
      end
      MODE_M68: begin
        cs_on   = strobe;
        oe_on   = 1'b0;
        we_on   = access && wr_d;
        lane_on = strobe ? mask_d : '0;
      end
      default: begin
        cs_on   = access;
        oe_on   = strobe && !wr_d;
        we_on   = 1'b0;
        lane_on = (strobe && wr_d) ? mask_d : '0;
      end
    endcase
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) cs_n[b] <= 1'b1;
      else     cs_n[b] <= !(cs_on && (bank_d == BANK_W'(b)));
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) lane_n[l] <= 1'b1;
      else     lane_n[l] <= !lane_on[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_n <= 1'b1;
      we_n <= 1'b1;
      doe  <= 1'b0;
    end else begin
      oe_n <= !oe_on;
      we_n <= !we_on;
      doe  <= access && wr_d;
    end
  end

endmodule

// File: rtl/xbus_strobe_ctrl.sv
module xbus_strobe_ctrl
  import xbus_pkg::*;
#(
  parameter  int NUM_BANKS = 5,
  parameter  int ADDR_W    = 16,
  parameter  int DATA_W    = 16,
  parameter  int SEL_W     = 2,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int LANES     = DATA_W / 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [LANES-1:0]     req_bmask,
  input  logic [NUM_BANKS-1:0] cfg_lane_en,
  input  logic [NUM_BANKS-1:0] cfg_m68,
  input  logic [SEL_W-1:0]     cfg_wait_sel,
  output logic                 busy,
  output logic                 rsp_done,
  output logic                 rsp_cfg_err,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 endian_le,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [DATA_W-1:0]    bus_dout,
  output logic                 bus_doe,
  input  logic [DATA_W-1:0]    bus_din,
  output logic [NUM_BANKS-1:0] bus_cs_n,
  output logic                 bus_oe_n,
  output logic                 bus_we_n,
  output logic [LANES-1:0]     bus_lane_n,
  input  logic                 bus_wait_n
);

  xb_state_e         state_q, state_d;
  xb_mode_e          sel_mode, mode_q, mode_d;
  logic              sel_rsv, bank_ok, accept, finish, ripe;
  logic              wr_q, wr_d, rsv_q;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [LANES-1:0]  mask_q, mask_d;
  logic [SEL_W-1:0]  wsel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              busy_q, done_q, err_q;

  xbus_mode_sel #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) mode_sel_i (
    .cfg_lane_en (cfg_lane_en),
    .cfg_m68     (cfg_m68),
    .bank        (req_bank),
    .mode        (sel_mode),
    .reserved    (sel_rsv),
    .bank_ok     (bank_ok)
  );

  xbus_wait_timer #(
    .SEL_W (SEL_W)
  ) wait_timer_i (
    .clk  (clk),
    .rst  (rst),
    .load (state_q == ST_SETUP),
    .run  (state_q == ST_STROBE),
    .sel  (wsel_q),
    .ripe (ripe)
  );

  assign accept = (state_q == ST_IDLE) && req_valid && bank_ok;
  assign finish = (state_q == ST_STROBE) && ripe && bus_wait_n;

  // Next values of the captured fields feed the registered pin stage.
  assign wr_d   = accept ? req_write : wr_q;
  assign bank_d = accept ? req_bank  : bank_q;
  assign mask_d = accept ? req_bmask : mask_q;
  assign mode_d = accept ? sel_mode  : mode_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_STROBE;
      ST_STROBE: if (finish) state_d = ST_HOLD;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_BSTRB;
      wr_q    <= 1'b0;
      rsv_q   <= 1'b0;
      bank_q  <= '0;
      mask_q  <= '0;
      wsel_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        mode_q  <= sel_mode;
        wr_q    <= req_write;
        rsv_q   <= sel_rsv;
        bank_q  <= req_bank;
        mask_q  <= req_bmask;
        wsel_q  <= cfg_wait_sel;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      busy_q <= (state_d != ST_IDLE);
      done_q <= (state_q == ST_HOLD);
      err_q  <= (state_q == ST_HOLD) && rsv_q;
      if (finish && !wr_q) rdata_q <= bus_din;
    end
  end

  xbus_pin_drive #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .LANES     (LANES)
  ) pin_drive_i (
    .clk     (clk),
    .rst     (rst),
    .state_d (state_d),
    .mode_d  (mode_d),
    .wr_d    (wr_d),
    .bank_d  (bank_d),
    .mask_d  (mask_d),
    .cs_n    (bus_cs_n),
    .oe_n    (bus_oe_n),
    .we_n    (bus_we_n),
    .lane_n  (bus_lane_n),
    .doe     (bus_doe)
  );

  assign busy        = busy_q;
  assign rsp_done    = done_q;
  assign rsp_cfg_err = err_q;
  assign rsp_rdata   = rdata_q;
  assign endian_le   = 1'b1;
  assign bus_addr    = addr_q;
  assign bus_dout    = wdata_q;

endmodule

// File: rtl/xbus_strobe_ctrl_chk.sv
module xbus_strobe_ctrl_chk #(
  parameter int NUM_BANKS = 5,
  parameter int DATA_W    = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 busy,
  input logic                 rsp_done,
  input logic                 rsp_cfg_err,
  input logic [DATA_W-1:0]    rsp_rdata,
  input logic [NUM_BANKS-1:0] bus_cs_n,
  input logic                 bus_oe_n,
  input logic                 bus_we_n,
  input logic                 bus_doe,
  input logic                 bus_wait_n
);

  assert_cs_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(~bus_cs_n) <= 1);

  assert_oe_inside_cs_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> (bus_cs_n != '1));

  assert_done_ends_busy_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (!busy && $past(busy)));

  assert_release_on_wait_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe_n) |-> $past(bus_wait_n));

  assert_no_dual_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !(!bus_oe_n && !bus_we_n));

  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_cfg_err |-> rsp_done);

  assert_rdata_only_busy_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(rsp_rdata) |-> busy);

  assert_doe_in_access_R12: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> busy);

endmodule

bind xbus_strobe_ctrl xbus_strobe_ctrl_chk #(
  .NUM_BANKS (NUM_BANKS),
  .DATA_W    (DATA_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .rsp_done    (rsp_done),
  .rsp_cfg_err (rsp_cfg_err),
  .rsp_rdata   (rsp_rdata),
  .bus_cs_n    (bus_cs_n),
  .bus_oe_n    (bus_oe_n),
  .bus_we_n    (bus_we_n),
  .bus_doe     (bus_doe),
  .bus_wait_n  (bus_wait_n)
);

// File: tb/xbus_strobe_ctrl_tb.sv
`timescale 1ns/1ps
module xbus_strobe_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [2:0]  req_bank;
  logic [15:0] req_addr, req_wdata;
  logic [1:0]  req_bmask;
  logic [4:0]  cfg_lane_en, cfg_m68;
  logic [1:0]  cfg_wait_sel;
  logic        busy, rsp_done, rsp_cfg_err, endian_le, bus_doe;
  logic [15:0] rsp_rdata, bus_addr, bus_dout, bus_din;
  logic [4:0]  bus_cs_n;
  logic        bus_oe_n, bus_we_n, bus_wait_n;
  logic [1:0]  bus_lane_n;

  int n_cmp = 0;
  int n_bad = 0;
  int seq   = 0;

  always #5 clk = ~clk;

  xbus_strobe_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_bmask(req_bmask), .cfg_lane_en(cfg_lane_en), .cfg_m68(cfg_m68),
    .cfg_wait_sel(cfg_wait_sel), .busy(busy), .rsp_done(rsp_done),
    .rsp_cfg_err(rsp_cfg_err), .rsp_rdata(rsp_rdata), .endian_le(endian_le),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_lane_n(bus_lane_n), .bus_wait_n(bus_wait_n)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Quiet state of the whole bus side (R1, also used after accesses for R2).
  task automatic chk_quiet(input string tag);
    chk(tag, "pins", {bus_cs_n, bus_oe_n, bus_we_n, bus_lane_n}, 32'h1ff);
    chk(tag, "busy/done/err/doe", {busy, rsp_done, rsp_cfg_err, bus_doe}, 32'h0);
  endtask

  // One access with cycle-by-cycle expected pins. Entered and left at a negedge.
  task automatic run_access(input int bank, input bit be, input bit m68,
                            input bit wr, input logic [1:0] mask,
                            input int sel, input int extra, input bit poke);
    int n = sel + 1;
    int len = n + extra;
    logic [15:0] pat, adr, wd;
    string mtag;
    int em;  // 0 byte strobe, 1 byte enable, 2 m68
    seq++;
    pat = 16'(seq * 16'h1357) ^ 16'ha5c3;
    adr = 16'(bank * 4096 + seq * 7);
    wd  = pat ^ 16'h0f0f;
    if (!be && m68)      begin em = 2; mtag = "R8"; end
    else if (be && !m68) begin em = 1; mtag = "R7"; end
    else if (be && m68)  begin em = 0; mtag = "R9"; end
    else                 begin em = 0; mtag = "R6"; end
    // other banks get the opposite pair (R10)
    cfg_lane_en = {5{~be}};  cfg_lane_en[bank] = be;
    cfg_m68     = {5{~m68}}; cfg_m68[bank]     = m68;
    cfg_wait_sel = 2'(sel);
    req_valid = 1'b1; req_write = wr; req_bank = 3'(bank);
    req_addr = adr; req_wdata = wd; req_bmask = mask;
    bus_wait_n = 1'b1; bus_din = ~pat;
    for (int c = 1; c <= 3 + len; c++) begin
      bit acc, stb, cs_on, oe, we;
      logic [1:0] ln;
      logic [4:0] cs_exp;
      @(negedge clk);
      if (c == 1) begin
        req_valid = 1'b0;
        // R10: the captured configuration must not follow these changes
        cfg_lane_en[bank] = ~be; cfg_m68[bank] = ~m68; cfg_wait_sel = ~2'(sel);
      end
      if (poke && c == 2) begin
        req_valid = 1'b1; req_bank = 3'((bank + 1) % 5); req_write = ~wr;
      end
      if (poke && c == 3) req_valid = 1'b0;
      acc = (c <= 2 + len);
      stb = (c >= 2) && (c <= 1 + len);
      case (em)
        1: begin cs_on = acc; oe = stb && !wr; we = stb && wr;
                 ln = acc ? mask : 2'b00; end
        2: begin cs_on = stb; oe = 1'b0; we = acc && wr;
                 ln = stb ? mask : 2'b00; end
        default: begin cs_on = acc; oe = stb && !wr; we = 1'b0;
                 ln = (stb && wr) ? mask : 2'b00; end
      endcase
      cs_exp = cs_on ? ~(5'b1 << bank) : 5'h1f;
      // R3 R4 R5 timing together with the mode tag
      chk({mtag, "/R3/R4/R5"}, $sformatf("pins c=%0d", c),
          {bus_cs_n, bus_oe_n, bus_we_n, bus_lane_n},
          {cs_exp, !oe, !we, ~ln});
      chk("R2", $sformatf("busy c=%0d", c), busy, acc);
      chk("R3", $sformatf("done c=%0d", c), rsp_done, (c == 3 + len));
      chk("R9", $sformatf("cfg_err c=%0d", c), rsp_cfg_err, (c == 3 + len) && be && m68);
      chk("R12", $sformatf("doe c=%0d", c), bus_doe, acc && wr);
      if (acc) chk("R12", "addr", bus_addr, adr);
      if (acc && wr) chk("R12", "dout", bus_dout, wd);
      if (c == 3 + len && !wr) chk("R11", "rdata", rsp_rdata, pat);
      bus_wait_n = !((c >= n + 1) && (c <= n + extra));
      bus_din = (c == 1 + len) ? pat : ~pat;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog expired act=busy exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_bank = '0;
    req_addr = '0; req_wdata = '0; req_bmask = '0; cfg_lane_en = '0;
    cfg_m68 = '0; cfg_wait_sel = '0; bus_din = '0; bus_wait_n = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_quiet("R1");
    chk("R11", "endian_le", endian_le, 1'b1);

    // R2: banks beyond the last one are ignored
    for (int b = 5; b < 8; b++) begin
      req_valid = 1'b1; req_bank = 3'(b);
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 3; k++) begin
        chk_quiet("R2");
        @(negedge clk);
      end
    end

    // Full sweep (R3..R12)
    for (int b = 0; b < 5; b++)
      for (int mp = 0; mp < 4; mp++)
        for (int w = 0; w < 2; w++)
          for (int m = 0; m < 4; m++)
            for (int s = 0; s < 4; s++)
              for (int x = 0; x < 2; x++)
                run_access(b, mp[1], mp[0], w[0], 2'(m), s, x * 2, 1'b0);

    // R2: a request during an access is dropped
    run_access(2, 1'b1, 1'b0, 1'b1, 2'b11, 1, 1, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk_quiet("R2");
    end
    chk("R11", "endian_le", endian_le, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule